// File: doc/BRIEF.md
# Buffered Saturating Error Counter Pair

This block keeps two independent error tallies for a line interface channel. One counts line code violations and the other counts pseudo-random test pattern bit errors. Each arrives as a one-cycle strobe. Each tally runs in a live register that the host never sees directly. The host reads a separate holding register, which is refreshed by a copy-and-restart operation.

The copy-and-restart has two triggers, selected by a mode input. In periodic mode, a one-second tick supplied from outside performs it. In on-demand mode, a host command performs it, and the block answers the command with a one-cycle acknowledge. The live counts stop at their all-ones value instead of wrapping. A strobe that lands in the same cycle as a copy is never lost: it becomes the first count of the new interval. Each tick also raises a sticky interrupt flag, which tells the host it is time to look at the counters. The flag stays up until the host clears it.

Top module: `err_cnt_pair`

## Requirements
- R1: After a synchronous reset, both holding outputs read 0, `cmd_ack` is 0, `tick_irq` is 0, and both live counts are 0.
- R2: Each cycle with `cv_evt` high adds one to the code-violation live count. Each cycle with `prbs_evt` high adds one to the bit-error live count. The two counts never affect each other.
- R3: A holding output changes only on the clock edge of a copy cycle and keeps its value in every other cycle.
- R4: With `upd_mode` = 1 (periodic), a cycle with `sec_tick` high is a copy cycle. After its edge, each holding output shows the live count that existed before the edge, and each live count restarts from 0.
- R5: With `upd_mode` = 0 (on demand), a cycle with `cmd_req` high is a copy cycle with the same effect as in R4, and `sec_tick` causes no copy.
- R6: `cmd_ack` is high for exactly the one cycle after each cycle with `cmd_req` high, in either mode. With `upd_mode` = 1, `cmd_req` causes no copy.
- R7: A live count that holds 0xFFFF stays at 0xFFFF on further events, and a later copy delivers 0xFFFF.
- R8: An event in a copy cycle is kept. The holding output receives the count from before that event, and the live count restarts at 1.
- R9: `tick_irq` rises in the cycle after any `sec_tick`, whatever the mode. It stays high until a cycle with `irq_clr` high and `sec_tick` low. If `sec_tick` and `irq_clr` are high in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cv_evt | input | 1 | Code-violation event strobe |
| prbs_evt | input | 1 | Test-pattern bit-error event strobe |
| sec_tick | input | 1 | One-second tick, one cycle wide |
| upd_mode | input | 1 | 1 = periodic copy on tick, 0 = copy on host command |
| cmd_req | input | 1 | Host copy command |
| cmd_ack | output | 1 | One-cycle acknowledge of cmd_req |
| cv_hold | output | 16 | Buffered code-violation count |
| prbs_hold | output | 16 | Buffered bit-error count |
| tick_irq | output | 1 | Sticky tick interrupt flag |
| irq_clr | input | 1 | Clears tick_irq |

## Verification
A wrong live count stays invisible until the next copy cycle. It then shows in a holding output one cycle after that copy's edge, so the bench issues copies often and compares the holding outputs against a model on every clock. Faults in saturation and in a coincident event show only at the copy that follows. For this reason the bench runs a count well past 0xFFFF and places events right on the copy cycles. Faults in the acknowledge and the interrupt flag show at the ports one cycle after the triggering input.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_CV   = 0;
  localparam int CH_PRBS = 1;

  typedef enum logic {
    UPD_ON_DEMAND = 1'b0,
    UPD_PERIODIC  = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/errcnt_chan.sv
module errcnt_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             snap,
  output logic [CNT_W-1:0] hold_q
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      hold_q <= '0;
    end else if (snap) begin
      hold_q <= live_q;
      live_q <= evt ? ONE : '0;
    end else if (evt && (live_q != MAXV)) begin
      live_q <= live_q + ONE;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q == MAXV && !snap) |=> (live_q == MAXV));

  // R8
  restart_one_chk: assert property (@(posedge clk) disable iff (rst)
    (snap && evt) |=> (live_q == ONE));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !snap |=> $stable(hold_q));

  // R4
  copy_value_chk: assert property (@(posedge clk) disable iff (rst)
    snap |=> (hold_q == $past(live_q)));
endmodule

// File: rtl/errcnt_ctrl.sv
module errcnt_ctrl
  import errcnt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic upd_mode,
  input  logic sec_tick,
  input  logic cmd_req,
  output logic snap,
  output logic cmd_ack
);
  upd_mode_e mode;
  assign mode = upd_mode_e'(upd_mode);

  always_comb begin
    unique case (mode)
      UPD_PERIODIC:  snap = sec_tick;
      UPD_ON_DEMAND: snap = cmd_req;
      default:       snap = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_ack <= 1'b0;
    else     cmd_ack <= cmd_req;
  end

  // R6
  ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_req |=> cmd_ack);

  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_req |=> !cmd_ack);
endmodule

// File: rtl/errcnt_irq.sv
module errcnt_irq (
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  input  logic irq_clr,
  output logic tick_irq
);
  always_ff @(posedge clk) begin
    if (rst)           tick_irq <= 1'b0;
    else if (sec_tick) tick_irq <= 1'b1;
    else if (irq_clr)  tick_irq <= 1'b0;
  end

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> tick_irq);

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_irq && !irq_clr) |=> tick_irq);
endmodule

// File: rtl/err_cnt_pair.sv
module err_cnt_pair
  import errcnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cv_evt,
  input  logic             prbs_evt,
  input  logic             sec_tick,
  input  logic             upd_mode,
  input  logic             cmd_req,
  output logic             cmd_ack,
  output logic [CNT_W-1:0] cv_hold,
  output logic [CNT_W-1:0] prbs_hold,
  output logic             tick_irq,
  input  logic             irq_clr
);
  logic                        snap;
  logic [NUM_CH-1:0]           evt_vec;
  logic [NUM_CH-1:0][CNT_W-1:0] hold_vec;

  assign evt_vec[CH_CV]   = cv_evt;
  assign evt_vec[CH_PRBS] = prbs_evt;

  errcnt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .upd_mode (upd_mode),
    .sec_tick (sec_tick),
    .cmd_req  (cmd_req),
    .snap     (snap),
    .cmd_ack  (cmd_ack)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    errcnt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .evt    (evt_vec[g]),
      .snap   (snap),
      .hold_q (hold_vec[g])
    );
  end

  assign cv_hold   = hold_vec[CH_CV];
  assign prbs_hold = hold_vec[CH_PRBS];

  errcnt_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .sec_tick (sec_tick),
    .irq_clr  (irq_clr),
    .tick_irq (tick_irq)
  );

  // R5
  demand_tick_nocopy_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_mode && !cmd_req) |=> ($stable(cv_hold) && $stable(prbs_hold)));
endmodule

// File: tb/tb_err_cnt_pair.sv
module tb_err_cnt_pair;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cv_evt = 0, prbs_evt = 0, sec_tick = 0, upd_mode = 1, cmd_req = 0, irq_clr = 0;
  logic cmd_ack, tick_irq;
  logic [15:0] cv_hold, prbs_hold;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  int m_cv_live = 0, m_pr_live = 0, m_cv_hold = 0, m_pr_hold = 0, m_ack = 0, m_irq = 0;

  always #10 clk = ~clk;

  err_cnt_pair dut (
    .clk(clk), .rst(rst), .cv_evt(cv_evt), .prbs_evt(prbs_evt),
    .sec_tick(sec_tick), .upd_mode(upd_mode), .cmd_req(cmd_req),
    .cmd_ack(cmd_ack), .cv_hold(cv_hold), .prbs_hold(prbs_hold),
    .tick_irq(tick_irq), .irq_clr(irq_clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " cv_hold"},   int'(cv_hold),   m_cv_hold);
    chk({tag, " prbs_hold"}, int'(prbs_hold), m_pr_hold);
    chk({tag, " cmd_ack (R6)"}, int'(cmd_ack), m_ack);
    chk({tag, " tick_irq (R9)"}, int'(tick_irq), m_irq);
  endtask

  // Drive one cycle; update the model for the edge; compare one delta later.
  task automatic step(input logic cv, input logic pr, input logic tk,
                      input logic md, input logic rq, input logic cl,
                      input string tag);
    bit snap;
    cv_evt = cv; prbs_evt = pr; sec_tick = tk; upd_mode = md; cmd_req = rq; irq_clr = cl;
    @(posedge clk);
    #1;
    snap = md ? tk : rq;
    if (snap) begin
      m_cv_hold = m_cv_live; m_cv_live = cv ? 1 : 0;
      m_pr_hold = m_pr_live; m_pr_live = pr ? 1 : 0;
    end else begin
      if (cv && m_cv_live < 65535) m_cv_live++;
      if (pr && m_pr_live < 65535) m_pr_live++;
    end
    m_ack = rq;
    if (tk) m_irq = 1; else if (cl) m_irq = 0;
    compare_all(tag);
  endtask

  task automatic idle(input logic md, input string tag);
    step(0, 0, 0, md, 0, 0, tag);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin : stim
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1: reset state
    chk("R1 cv_hold reset", int'(cv_hold), 0);
    chk("R1 prbs_hold reset", int'(prbs_hold), 0);
    chk("R1 cmd_ack reset", int'(cmd_ack), 0);
    chk("R1 tick_irq reset", int'(tick_irq), 0);
    step(0, 0, 1, 1, 0, 0, "R1 live zero after reset");
    chk("R1 cv_hold after first copy", int'(cv_hold), 0);
    step(0, 0, 0, 1, 0, 1, "R9 clear");

    // R2 / R4: periodic counting, independent channels
    for (int i = 0; i < 5; i++) step(1, i < 3, 0, 1, 0, 0, "R2 count");
    step(0, 0, 1, 1, 0, 0, "R4 tick copy");
    chk("R4 cv_hold=5", int'(cv_hold), 5);
    chk("R2 prbs_hold=3", int'(prbs_hold), 3);

    // R3: buffers hold while live counts run
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 0, 0, "R3 hold");
    chk("R3 cv_hold unchanged", int'(cv_hold), 5);

    // R8: event coincides with copy
    step(1, 1, 1, 1, 0, 0, "R8 coincident copy");
    chk("R8 prbs_hold pre-event", int'(prbs_hold), 4);
    step(0, 0, 1, 1, 0, 0, "R8 restart at one");
    chk("R8 cv_hold=1", int'(cv_hold), 1);

    // R6: command in periodic mode acknowledged, no copy
    step(1, 0, 0, 1, 0, 0, "R6 setup");
    step(0, 0, 0, 1, 1, 0, "R6 periodic cmd");
    chk("R6 no copy in periodic", int'(cv_hold), 1);
    idle(1, "R6 ack drop");
    chk("R6 ack single cycle", int'(cmd_ack), 0);

    // R5: on-demand; tick does not copy but sets irq (R9)
    step(0, 0, 0, 0, 0, 1, "R9 clear");
    for (int i = 0; i < 7; i++) step(1, i[0], 0, 0, 0, 0, "R5 count");
    step(0, 0, 1, 0, 0, 0, "R5 tick ignored");
    chk("R5 no copy on tick", int'(cv_hold), 1);
    chk("R9 irq in on-demand", int'(tick_irq), 1);
    step(0, 0, 0, 0, 1, 0, "R5 cmd copy");
    chk("R5 cv_hold=8", int'(cv_hold), 8);
    chk("R6 ack after cmd", int'(cmd_ack), 1);

    // R9: irq sticky, clear, set wins over clear
    idle(0, "R9 sticky");
    step(0, 0, 0, 0, 0, 1, "R9 clear");
    chk("R9 cleared", int'(tick_irq), 0);
    step(0, 0, 1, 0, 0, 1, "R9 set beats clear");
    chk("R9 set wins", int'(tick_irq), 1);

    // R7: saturation
    for (int i = 0; i < 65540; i++) step(1, i < 65535, 0, 0, 0, 0, "R7 fill");
    step(1, 1, 0, 0, 1, 0, "R7 copy at max");
    chk("R7 cv_hold saturated", int'(cv_hold), 65535);
    chk("R7 prbs_hold saturated", int'(prbs_hold), 65535);
    step(0, 0, 0, 0, 1, 0, "R8 after saturated copy");
    chk("R8 cv_hold=1 after saturated copy", int'(cv_hold), 1);

    // Mixed random traffic across both modes
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step(r[0], r[1], (r[7:2] == 0), (i >= 1500), (r[12:9] == 0), (r[15:13] == 0),
           "R2 R4 R5 R8 mixed");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule